// File: doc/BRIEF.md
# Dual-Clause MDIO Management Master

This block is the station-management master that reads and writes single PHY registers over a two-wire management bus. It divides the system clock down to produce the management clock (MDC). It drives the serial data line through a separate output value and output enable, and it reads the line back through an input pin. A host asks for one transfer by pulsing a start strobe together with a read/write select, a 5-bit port address, a 32-bit register number and 16 bits of write data. The block answers with a one-cycle done pulse, the read data and an error flag.

Legacy clause 22 devices and extended clause 45 devices can share the bus. A clause 22 request is sent as one frame. When bit 30 of the register number is set, the request is a clause 45 request. It is sent as two frames: first an address frame that loads the 16-bit register offset into the addressed device, then the read or write frame itself. Clause 22 devices ignore clause 45 address frames.

Top module: `mdio_master`

## Requirements
- R1: Every frame opens with exactly 32 one bits driven by the master (`mdio_oe` high) before the start field.
- R2: The start field is 01 in clause 22 frames and 00 in clause 45 frames.
- R3: The opcode field is 10 for a clause 22 read and 01 for a clause 22 write. In clause 45 it is 00 for the address frame, 11 for a read and 01 for a write.
- R4: After the opcode the master sends the 5-bit port address and then a 5-bit field, both most significant bit first. The field is `reg_num[4:0]` in clause 22 mode and the device ID `reg_num[20:16]` in clause 45 mode. Other register-number bits do not reach this field.
- R5: When `reg_num[30]` is 1, the request first emits an address frame. That frame carries turnaround 10 and then `reg_num[15:0]`, and it is followed by one MDC bit with MDIO released before the read or write frame starts.
- R6: A write frame carries the turnaround bits 1 then 0, followed by the 16 write-data bits, most significant first, all driven by the master.
- R7: A read frame releases MDIO from the first turnaround bit to the end of the frame. The 16 bits the PHY returns, sampled on MDC rising edges, appear on `rdata` when `done` pulses.
- R8: If the second turnaround bit of a read reads back as 1, the request completes with `err` high and `rdata` equal to 16'hFFFF.
- R9: MDC has a period of 2*HALF_DIV system clocks. `mdio_o` and `mdio_oe` change only in the cycle in which MDC falls.
- R10: Every frame is followed by one MDC bit with MDIO released. The end of the last such bit brings a single-cycle `done` pulse, and `busy` is already low in that cycle.
- R11: `busy` rises after an accepted start and stays high until `done`. Start strobes that arrive while busy are ignored and produce no frame and no `done`. A start in the `done` cycle is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request strobe, taken only while idle |
| rd_nwr | input | 1 | 1 = read, 0 = write |
| port_addr | input | 5 | PHY port address |
| reg_num | input | 32 | Register number; bit 30 selects clause 45, bits 20:16 device ID, bits 15:0 offset |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data, valid with done |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Read turnaround error, valid with done |
| busy | output | 1 | Transfer in progress |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Data value driven onto MDIO |
| mdio_oe | output | 1 | MDIO output enable |
| mdio_i | input | 1 | MDIO line level read back |

## Verification
The completion pulse and the acceptance of the next start strobe can fall in the same cycle. The bench issues every request back-to-back, raising the next start in the very cycle that shows `done`. It then requires `busy` one cycle later and a complete, correctly framed transfer after that. In the opposite case, a strobe raised midway through a clause 45 write must be ignored. This is judged at the bus: a PHY model decodes every frame against a queue of expected frames, so a stray frame or an extra done pulse shows up as an unmatched item.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
    localparam int PORT_W    = 5;
    localparam int FIELD_W   = 5;
    localparam int DATA_W    = 16;
    localparam int PRE_LEN   = 32;
    localparam int HDR_LEN   = 4 + PORT_W + FIELD_W;
    localparam int TA_LEN    = 2;
    localparam int FRAME_LEN = PRE_LEN + HDR_LEN + TA_LEN + DATA_W;
    localparam int BIT_W     = $clog2(FRAME_LEN);
    localparam int TA_POS    = PRE_LEN + HDR_LEN;
    localparam int DATA_POS  = TA_POS + TA_LEN;
    localparam int C45_SEL   = 30;
    localparam int DEV_LSB   = 16;

    localparam logic [1:0] SOF_LEGACY = 2'b01;
    localparam logic [1:0] SOF_EXT    = 2'b00;
    localparam logic [1:0] OPC_L_RD   = 2'b10;
    localparam logic [1:0] OPC_L_WR   = 2'b01;
    localparam logic [1:0] OPC_E_AD   = 2'b00;
    localparam logic [1:0] OPC_E_RD   = 2'b11;
    localparam logic [1:0] OPC_E_WR   = 2'b01;

    typedef enum logic [1:0] {ST_IDLE, ST_ARM, ST_SHIFT, ST_GAP} mst_state_e;

    typedef struct packed {
        mst_state_e           st;
        logic [BIT_W-1:0]     bitcnt;
        logic [FRAME_LEN-1:0] word;
        logic                 mdo;
        logic                 oe;
        logic                 rd_frame;
        logic                 addr_ph;
        logic                 pend;
        logic                 rd;
        logic                 c45;
        logic [PORT_W-1:0]    port;
        logic [FIELD_W-1:0]   lreg;
        logic [FIELD_W-1:0]   dev;
        logic [DATA_W-1:0]    offs;
        logic [DATA_W-1:0]    wdat;
        logic [DATA_W-1:0]    rdata;
        logic                 err;
        logic                 done;
    } mst_regs_t;
endpackage

// File: rtl/mdio_mdc_gen.sv
module mdio_mdc_gen #(
    parameter int HALF_DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    output logic mdc,
    output logic fall_tick,
    output logic rise_tick
);
    localparam int CNT_W = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
    localparam logic [CNT_W-1:0] TERM = CNT_W'(HALF_DIV - 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             clk_lvl;
    } gen_regs_t;

    gen_regs_t q, n;
    logic      tick;

    assign tick      = (q.cnt == TERM);
    assign fall_tick = tick && q.clk_lvl;
    assign rise_tick = tick && !q.clk_lvl;
    assign mdc       = q.clk_lvl;

    always_comb begin
        n = q;
        if (tick) begin
            n.cnt     = '0;
            n.clk_lvl = !q.clk_lvl;
        end else begin
            n.cnt = q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= n;
    end

    AST_MDC_RISES_AFTER_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        rise_tick |=> mdc); // R9
    AST_MDC_FALLS_AFTER_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        fall_tick |=> !mdc); // R9
endmodule

// File: rtl/mdio_frame_fmt.sv
module mdio_frame_fmt
    import mdio_pkg::*;
(
    input  logic                 c45,
    input  logic                 addr_phase,
    input  logic                 rd,
    input  logic [PORT_W-1:0]    port,
    input  logic [FIELD_W-1:0]   legacy_reg,
    input  logic [FIELD_W-1:0]   dev_id,
    input  logic [DATA_W-1:0]    offset,
    input  logic [DATA_W-1:0]    wdata,
    output logic [FRAME_LEN-1:0] word,
    output logic                 rd_frame
);
    logic [1:0]         sof, opc, ta;
    logic [FIELD_W-1:0] fld;
    logic [DATA_W-1:0]  payload;

    always_comb begin
        rd_frame = rd && !(c45 && addr_phase);
        sof      = c45 ? SOF_EXT : SOF_LEGACY;
        if (c45) opc = addr_phase ? OPC_E_AD : (rd ? OPC_E_RD : OPC_E_WR);
        else     opc = rd ? OPC_L_RD : OPC_L_WR;
        fld      = c45 ? dev_id : legacy_reg;
        // released bits are filled with ones; the enable is low there anyway
        ta       = rd_frame ? 2'b11 : 2'b10;
        payload  = rd_frame ? '1 : ((c45 && addr_phase) ? offset : wdata);
        word     = {{PRE_LEN{1'b1}}, sof, opc, port, fld, ta, payload};
    end
endmodule

// File: rtl/mdio_master.sv
module mdio_master
    import mdio_pkg::*;
#(
    parameter int HALF_DIV = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    input  logic        rd_nwr,
    input  logic [4:0]  port_addr,
    input  logic [31:0] reg_num,
    input  logic [15:0] wdata,
    output logic [15:0] rdata,
    output logic        done,
    output logic        err,
    output logic        busy,
    output logic        mdc,
    output logic        mdio_o,
    output logic        mdio_oe,
    input  logic        mdio_i
);
    localparam logic [BIT_W-1:0] LAST_BIT  = BIT_W'(FRAME_LEN - 1);
    localparam logic [BIT_W-1:0] TA_FIRST  = BIT_W'(TA_POS);
    localparam logic [BIT_W-1:0] TA_SECOND = BIT_W'(TA_POS + 1);
    localparam logic [BIT_W-1:0] DATA_FIRST = BIT_W'(DATA_POS);

    mst_regs_t            q, n;
    logic                 fall_tick, rise_tick;
    logic [FRAME_LEN-1:0] fmt_word;
    logic                 fmt_rd;
    logic [BIT_W-1:0]     next_bit;
    logic                 unused_hi;

    assign unused_hi = ^{reg_num[31], reg_num[29:21], reg_num[15:5]};

    mdio_mdc_gen #(.HALF_DIV(HALF_DIV)) u_mdc (
        .clk       (clk),
        .rst_n     (rst_n),
        .mdc       (mdc),
        .fall_tick (fall_tick),
        .rise_tick (rise_tick)
    );

    mdio_frame_fmt u_fmt (
        .c45        (q.c45),
        .addr_phase (q.addr_ph),
        .rd         (q.rd),
        .port       (q.port),
        .legacy_reg (q.lreg),
        .dev_id     (q.dev),
        .offset     (q.offs),
        .wdata      (q.wdat),
        .word       (fmt_word),
        .rd_frame   (fmt_rd)
    );

    assign next_bit = q.bitcnt + 1'b1;

    always_comb begin
        n      = q;
        n.done = 1'b0;
        case (q.st)
            ST_IDLE: begin
                if (start) begin
                    n.st      = ST_ARM;
                    n.rd      = rd_nwr;
                    n.port    = port_addr;
                    n.c45     = reg_num[C45_SEL];
                    n.addr_ph = reg_num[C45_SEL];
                    n.lreg    = reg_num[FIELD_W-1:0];
                    n.dev     = reg_num[DEV_LSB +: FIELD_W];
                    n.offs    = reg_num[DATA_W-1:0];
                    n.wdat    = wdata;
                end
            end
            ST_SHIFT: begin
                if (rise_tick && q.rd_frame) begin
                    if (q.bitcnt == TA_SECOND) n.err = mdio_i;
                    if (q.bitcnt >= DATA_FIRST) n.rdata = {q.rdata[DATA_W-2:0], mdio_i};
                end
                if (fall_tick) begin
                    if (q.bitcnt == LAST_BIT) begin
                        n.st      = ST_GAP;
                        n.oe      = 1'b0;
                        n.pend    = q.addr_ph;
                        n.addr_ph = 1'b0;
                    end else begin
                        n.bitcnt = next_bit;
                        n.word   = q.word << 1;
                        n.mdo    = q.word[FRAME_LEN-2];
                        n.oe     = !(q.rd_frame && (next_bit >= TA_FIRST));
                    end
                end
            end
            ST_GAP: begin
                if (fall_tick && !q.pend) begin
                    n.st   = ST_IDLE;
                    n.done = 1'b1;
                    if (q.rd_frame && q.err) n.rdata = '1;
                end
            end
            default: ;
        endcase
        // frame launch: first frame after start, or the operation frame after an address frame
        if (fall_tick && (q.st == ST_ARM || (q.st == ST_GAP && q.pend))) begin
            n.st       = ST_SHIFT;
            n.pend     = 1'b0;
            n.word     = fmt_word;
            n.rd_frame = fmt_rd;
            n.mdo      = fmt_word[FRAME_LEN-1];
            n.oe       = 1'b1;
            n.bitcnt   = '0;
            n.err      = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= n;
    end

    assign rdata   = q.rdata;
    assign done    = q.done;
    assign err     = q.err;
    assign busy    = (q.st != ST_IDLE);
    assign mdio_o  = q.mdo;
    assign mdio_oe = q.oe;

    AST_MDO_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(mdio_o) |-> $fell(mdc)); // R9
    AST_OE_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(mdio_oe) |-> $fell(mdc)); // R9
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R10
    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy && !mdio_oe); // R10
    AST_DRIVE_NEEDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        mdio_oe |-> busy); // R11
    AST_ERR_ALL_ONES: assert property (@(posedge clk) disable iff (!rst_n)
        (done && err) |-> (rdata == 16'hFFFF)); // R8
endmodule

// File: tb/tb_mdio_master.sv
module tb_mdio_master;
    localparam int HD = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        rd_nwr = 1'b0;
    logic [4:0]  port_addr = '0;
    logic [31:0] reg_num = '0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic        done, err, busy, mdc, mdio_o, mdio_oe, mdio_i;
    logic        phy_en = 1'b0;
    logic        phy_val = 1'b1;
    logic        inj_err = 1'b0;

    int n_checks = 0;
    int n_fail = 0;
    int done_cnt = 0;
    int exp_done = 0;
    bit finished = 0;

    typedef struct packed {
        logic [1:0]  sof;
        logic [1:0]  op;
        logic [4:0]  port;
        logic [4:0]  fld;
        logic [1:0]  ta;
        logic [15:0] data;
    } frm_t;
    typedef struct packed {
        logic        rd;
        logic        err;
        logic [15:0] rdata;
    } res_t;

    frm_t exp_frm[$];
    res_t exp_res[$];

    always #5 clk = ~clk;

    assign mdio_i = phy_en ? phy_val : 1'b1;

    mdio_master #(.HALF_DIV(HD)) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .rd_nwr(rd_nwr),
        .port_addr(port_addr), .reg_num(reg_num), .wdata(wdata),
        .rdata(rdata), .done(done), .err(err), .busy(busy),
        .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    function automatic logic line_lvl();
        return mdio_oe ? mdio_o : mdio_i;
    endfunction

    task automatic cmp_frame(input frm_t o);
        frm_t e;
        if (exp_frm.size() == 0) begin
            chk(1'b0, "R11 unexpected frame", {16'h0, o.sof, o.op, o.port, o.fld, 2'b0}, 32'h0);
            return;
        end
        e = exp_frm.pop_front();
        chk(o.sof == e.sof, "R2 start field", 32'(o.sof), 32'(e.sof));
        chk(o.op == e.op, "R3 opcode", 32'(o.op), 32'(e.op));
        chk(o.port == e.port, "R4 port address", 32'(o.port), 32'(e.port));
        chk(o.fld == e.fld, "R4 register or device field", 32'(o.fld), 32'(e.fld));
        chk(o.ta == e.ta, "R5 R6 R8 turnaround", 32'(o.ta), 32'(e.ta));
        chk(o.data == e.data, "R5 R6 R7 data field", 32'(o.data), 32'(e.data));
    endtask

    // PHY model: decodes frames on MDC rising edges and answers reads on falling edges
    initial begin
        int ones;
        int drv;
        logic b;
        logic [12:0] hdr;
        logic [15:0] last_off;
        logic [15:0] val;
        frm_t o;
        bit is_rd;
        last_off = '0;
        forever begin
            ones = 0;
            drv = 0;
            forever begin
                @(posedge mdc);
                b = line_lvl();
                if (b) begin
                    ones++;
                    drv = mdio_oe ? drv + 1 : 0;
                end else if (ones >= 32) begin
                    break;
                end else begin
                    ones = 0;
                    drv = 0;
                end
            end
            chk(drv == 32 && mdio_oe, "R1 driven preamble length", 32'(drv), 32'd32);
            hdr = '0;
            for (int i = 0; i < 13; i++) begin
                @(posedge mdc);
                hdr = {hdr[11:0], line_lvl()};
            end
            o = '0;
            o.sof  = {1'b0, hdr[12]};
            o.op   = hdr[11:10];
            o.port = hdr[9:5];
            o.fld  = hdr[4:0];
            is_rd = (hdr[12] && o.op == 2'b10) || (!hdr[12] && o.op == 2'b11);
            if (is_rd) begin
                val = hdr[12] ? {o.fld, o.port, 6'h2D} : (last_off ^ 16'hC3A5);
                @(negedge mdc);
                @(posedge mdc);
                chk(!mdio_oe, "R7 master released at turnaround", 32'(mdio_oe), 32'd0);
                o.ta[1] = line_lvl();
                @(negedge mdc);
                phy_en = 1'b1;
                phy_val = inj_err;
                @(posedge mdc);
                o.ta[0] = line_lvl();
                for (int i = 0; i < 16; i++) begin
                    @(negedge mdc);
                    phy_val = val[15-i];
                    @(posedge mdc);
                    chk(!mdio_oe, "R7 master released during data", 32'(mdio_oe), 32'd0);
                    o.data = {o.data[14:0], line_lvl()};
                end
                @(negedge mdc);
                phy_en = 1'b0;
            end else begin
                for (int i = 0; i < 18; i++) begin
                    @(posedge mdc);
                    if (i == 0 || i == 17)
                        chk(mdio_oe, "R6 master drives turnaround and data", 32'(mdio_oe), 32'd1);
                    if (i < 2) o.ta = {o.ta[0], line_lvl()};
                    else       o.data = {o.data[14:0], line_lvl()};
                end
                if (!hdr[12] && o.op == 2'b00) last_off = o.data;
            end
            cmp_frame(o);
            @(posedge mdc);
            chk(!mdio_oe, "R5 R10 released idle bit after frame", 32'(mdio_oe), 32'd0);
        end
    end

    // completion monitor
    always @(negedge clk) begin
        res_t r;
        if (rst_n && done) begin
            done_cnt++;
            chk(!busy, "R10 busy low in done cycle", 32'(busy), 32'd0);
            if (exp_res.size() == 0) begin
                chk(1'b0, "R11 unexpected done", 32'd1, 32'd0);
            end else begin
                r = exp_res.pop_front();
                chk(err == r.err, "R8 error flag", 32'(err), 32'(r.err));
                if (r.rd) chk(rdata == r.rdata, "R7 R8 read data", 32'(rdata), 32'(r.rdata));
            end
        end
    end

    task automatic do_req(input bit rd, input logic [4:0] port, input logic [31:0] rn,
                          input logic [15:0] wd, input bit inj);
        frm_t f;
        res_t r;
        logic [15:0] val;
        bit c45;
        c45 = rn[30];
        if (c45) begin
            f = '{sof: 2'b00, op: 2'b00, port: port, fld: rn[20:16], ta: 2'b10, data: rn[15:0]};
            exp_frm.push_back(f);
            val = rn[15:0] ^ 16'hC3A5;
        end else begin
            val = {rn[4:0], port, 6'h2D};
        end
        f.sof  = c45 ? 2'b00 : 2'b01;
        f.op   = c45 ? (rd ? 2'b11 : 2'b01) : (rd ? 2'b10 : 2'b01);
        f.port = port;
        f.fld  = c45 ? rn[20:16] : rn[4:0];
        f.ta   = rd ? {1'b1, inj} : 2'b10;
        f.data = rd ? val : wd;
        exp_frm.push_back(f);
        r.rd = rd;
        r.err = rd && inj;
        r.rdata = inj ? 16'hFFFF : val;
        exp_res.push_back(r);
        exp_done++;
        inj_err = inj;
        start = 1'b1;
        rd_nwr = rd;
        port_addr = port;
        reg_num = rn;
        wdata = wd;
        @(negedge clk);
        start = 1'b0;
        chk(busy, "R11 busy after accepted start", 32'(busy), 32'd1);
        do @(negedge clk); while (!done);
    endtask

    initial begin
        repeat (20 * 200000) @(posedge clk);
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL R11 watchdog act=hung exp=complete");
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        time t0;
        time t1;
        repeat (4) @(negedge clk);
        chk(!busy && !done && !mdio_oe, "R11 reset state", {29'h0, busy, done, mdio_oe}, 32'h0);
        rst_n = 1'b1;
        @(posedge mdc);
        t0 = $time;
        @(posedge mdc);
        t1 = $time;
        chk((t1 - t0) == 64'(2 * HD * 10), "R9 MDC period", 32'(t1 - t0), 32'(2 * HD * 10));
        @(negedge clk);
        do_req(1'b0, 5'd5, 32'h0000_0012, 16'hA55A, 1'b0);
        do_req(1'b1, 5'd3, 32'h0000_0007, 16'h0000, 1'b0);
        fork
            begin
                repeat (120) @(negedge clk);
                chk(busy, "R11 busy when stray start raised", 32'(busy), 32'd1);
                start = 1'b1;
                rd_nwr = 1'b1;
                port_addr = 5'd9;
                reg_num = 32'h0000_0004;
                @(negedge clk);
                start = 1'b0;
            end
        join_none
        do_req(1'b0, 5'd1, 32'h401E_BEEF, 16'h1234, 1'b0);
        do_req(1'b1, 5'd31, 32'h4003_0001, 16'h0000, 1'b0);
        do_req(1'b1, 5'd10, 32'h0000_0015, 16'h0000, 1'b1);
        do_req(1'b1, 5'd2, 32'h4007_8421, 16'h0000, 1'b1);
        do_req(1'b0, 5'd17, 32'hBFA0_0FE3, 16'h8001, 1'b0);
        do_req(1'b1, 5'd0, 32'h0000_001F, 16'h0000, 1'b0);
        repeat (20 * HD) @(negedge clk);
        chk(done_cnt == exp_done, "R11 done count", 32'(done_cnt), 32'(exp_done));
        chk(exp_frm.size() == 0, "R11 frames outstanding", 32'(exp_frm.size()), 32'd0);
        chk(!busy, "R11 idle at end", 32'(busy), 32'd0);
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end
endmodule